// File: doc/BRIEF.md
# DMA Transfer Address and Count Sequencer

This block is the per-transfer datapath of one legacy-style DMA channel. Software-side logic loads a 16-bit starting address, a 16-bit count and an 8-bit page. The block then steps through a run of transfers, one for each strobe, and presents a 24-bit physical bus address for each one. In byte mode the page supplies the top eight address bits and each step moves one byte. In word mode the 16-bit counter is shifted left by one, page bit 0 is dropped and address bit 0 is held at zero, so each step moves one 16-bit word.

The count register holds the number of transfers minus one. The transfer that finds the count at zero is the final one, and a terminal-count pulse accompanies it. The address counter never carries into the page. It wraps inside a 64K region in byte mode and inside a 128K region in word mode. When terminal count is reached, the channel either masks itself until the next load, or, with autoinitialize enabled, reloads the current address and count from the stored base values and keeps running.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the bus address is 0 and tc_o is low. The channel is masked, so strobes are ignored until the first load.
- R2: A load copies base_addr_i and base_cnt_i into both the base and the current registers, latches page_i and unmasks the channel. The new address is visible on bus_addr_o in the cycle after the load edge.
- R3: In byte mode (word_mode_i = 0), bus_addr_o = {page[7:0], cur_addr[15:0]}.
- R4: In word mode (word_mode_i = 1), bus_addr_o = {page[7:1], cur_addr[15:0], 0}. Page bit 0 has no effect, bus_addr_o[0] is 0, and word_xfer_o is 1.
- R5: Each accepted strobe advances the current address by one. It wraps from 0xFFFF to 0x0000 without changing the page bits on the bus, so the wrap stays within 64K (byte mode) or 128K (word mode).
- R6: A loaded count C gives exactly C+1 transfers. tc_o is high, combinationally with the strobe, only during the transfer that finds the count at 0x0000, and the count then goes to 0xFFFF.
- R7: Without autoinitialize, strobes after terminal count are ignored: the bus address holds and tc_o stays low until the next load.
- R8: With autoinit_i = 1 at terminal count, the current address and count reload from their base values, and the channel keeps accepting strobes.
- R9: A load in the same cycle as a strobe wins. The strobe is not counted and tc_o stays low.
- R10: A loaded count of 0xFFFF gives 65536 transfers, with exactly one terminal-count pulse, on the last of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load base address, count and page |
| base_addr_i | input | 16 | Starting address (counter units) |
| base_cnt_i | input | 16 | Transfer count minus one |
| page_i | input | 8 | Page value |
| word_mode_i | input | 1 | 0 = byte transfers, 1 = word transfers |
| autoinit_i | input | 1 | Reload from base at terminal count |
| strobe_i | input | 1 | One transfer is performed this cycle |
| bus_addr_o | output | 24 | Physical address of the current transfer |
| word_xfer_o | output | 1 | High when transfers are 16-bit words |
| tc_o | output | 1 | Terminal-count pulse with the final transfer |

## Verification
The bench uses the default widths: a 16-bit address and count and an 8-bit page. At these widths the 0xFFFF-to-0x0000 wrap can be reached directly by loading 0xFFFF. They also make a full 65536-transfer run short enough to execute end to end, which covers the maximum-count case and the single terminal pulse at its end. Both page-bit-0 values are applied in word mode to show that the bit is discarded.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int DEF_ADDR_W = 16;
    localparam int DEF_PAGE_W = 8;

    typedef enum logic {
        XFER_BYTE = 1'b0,
        XFER_WORD = 1'b1
    } xfer_mode_e;

    typedef struct packed {
        logic accept;   // strobe taken this cycle
        logic last;     // count sits at zero
        logic reload;   // autoinit restart at terminal count
    } step_ctl_t;

endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
    parameter int W = dma_seq_pkg::DEF_ADDR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] base_i,
    input  logic         step_i,
    input  logic         reload_i,
    output logic [W-1:0] cur_o
);

    logic [W-1:0] base_q;
    logic [W-1:0] cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (load_i) begin
            base_q <= base_i;
            cur_q  <= base_i;
        end else if (reload_i) begin
            cur_q  <= base_q;
        end else if (step_i) begin
            cur_q  <= cur_q + W'(1);   // wraps inside W bits, never into page
        end
    end

    assign cur_o = cur_q;

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && !reload_i) |=> (cur_o == $past(cur_o) + W'(1)));

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cur_o == $past(base_i)));

endmodule

// File: rtl/dma_cnt_ctr.sv
module dma_cnt_ctr #(
    parameter int W = dma_seq_pkg::DEF_ADDR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] base_i,
    input  logic         step_i,
    input  logic         autoinit_i,
    output logic         last_o,
    output logic         active_o
);

    logic [W-1:0] base_q;
    logic [W-1:0] cur_q;
    logic         mask_q;

    assign last_o   = (cur_q == '0);
    assign active_o = ~mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
            mask_q <= 1'b1;
        end else if (load_i) begin
            base_q <= base_i;
            cur_q  <= base_i;
            mask_q <= 1'b0;
        end else if (step_i) begin
            if (last_o && autoinit_i) begin
                cur_q <= base_q;
            end else begin
                cur_q <= cur_q - W'(1);
                if (last_o) mask_q <= 1'b1;
            end
        end
    end

    // R7
    tc_masks_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && last_o && !autoinit_i && !load_i) |=> !active_o);

    // R8
    auto_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && last_o && autoinit_i && !load_i) |=> active_o);

    // R2
    load_unmask_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> active_o);

endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int PAGE_W = DEF_PAGE_W,
    localparam int PHYS_W = ADDR_W + PAGE_W
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  xfer_mode_e        mode_i,
    output logic [PHYS_W-1:0] phys_o
);

    always_comb begin
        if (mode_i == XFER_WORD) begin
            phys_o = {page_i[PAGE_W-1:1], addr_i, 1'b0};
        end else begin
            phys_o = {page_i, addr_i};
        end
    end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int PAGE_W = DEF_PAGE_W,
    localparam int PHYS_W = ADDR_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [ADDR_W-1:0] base_cnt_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              word_mode_i,
    input  logic              autoinit_i,
    input  logic              strobe_i,
    output logic [PHYS_W-1:0] bus_addr_o,
    output logic              word_xfer_o,
    output logic              tc_o
);

    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              active;
    step_ctl_t         ctl;
    xfer_mode_e        mode;

    assign mode       = xfer_mode_e'(word_mode_i);
    assign ctl.accept = strobe_i & ~load_i & active;
    assign ctl.reload = ctl.accept & ctl.last & autoinit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (load_i) begin
            page_q <= page_i;
        end
    end

    dma_cnt_ctr #(.W(ADDR_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .base_i     (base_cnt_i),
        .step_i     (ctl.accept),
        .autoinit_i (autoinit_i),
        .last_o     (ctl.last),
        .active_o   (active)
    );

    dma_addr_ctr #(.W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .base_i   (base_addr_i),
        .step_i   (ctl.accept),
        .reload_i (ctl.reload),
        .cur_o    (cur_addr)
    );

    dma_phys_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
        .page_i (page_q),
        .addr_i (cur_addr),
        .mode_i (mode),
        .phys_o (bus_addr_o)
    );

    assign word_xfer_o = (mode == XFER_WORD);
    assign tc_o        = ctl.accept & ctl.last;

    // R4
    word_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        word_xfer_o |-> (bus_addr_o[0] == 1'b0));

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !tc_o);

    // R7
    masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !load_i) |=> $stable(cur_addr));

endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [15:0] base_addr_i = '0;
    logic [15:0] base_cnt_i = '0;
    logic [7:0]  page_i = '0;
    logic        word_mode_i = 1'b0;
    logic        autoinit_i = 1'b0;
    logic        strobe_i = 1'b0;
    logic [23:0] bus_addr_o;
    logic        word_xfer_o;
    logic        tc_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_seq u_dma_xfer_seq (
        .clk(clk), .rst(rst), .load_i(load_i), .base_addr_i(base_addr_i),
        .base_cnt_i(base_cnt_i), .page_i(page_i), .word_mode_i(word_mode_i),
        .autoinit_i(autoinit_i), .strobe_i(strobe_i), .bus_addr_o(bus_addr_o),
        .word_xfer_o(word_xfer_o), .tc_o(tc_o)
    );

    function automatic logic [23:0] exp_phys(input logic [7:0] pg, input logic [15:0] a,
                                             input logic wm);
        if (wm) return {pg[7:1], a, 1'b0};
        return {pg, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_load(input logic [15:0] a, input logic [15:0] c, input logic [7:0] pg,
                           input logic wm, input logic ai);
        load_i = 1'b1; base_addr_i = a; base_cnt_i = c; page_i = pg;
        word_mode_i = wm; autoinit_i = ai;
        @(negedge clk);
        load_i = 1'b0;
        #1;
    endtask

    task automatic step(input string req, input logic tc_exp);
        strobe_i = 1'b1;
        #1 check(req, tc_o, tc_exp);
        @(negedge clk);
        strobe_i = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        check("R1 reset addr", bus_addr_o, 24'h0);
        check("R1 reset tc", tc_o, 1'b0);
        step("R1 masked strobe tc", 1'b0);
        check("R1 masked strobe addr", bus_addr_o, 24'h0);
    endtask

    task automatic t_byte;
        do_load(16'h1234, 16'd2, 8'h5A, 1'b0, 1'b0);
        check("R2/R3 load addr", bus_addr_o, exp_phys(8'h5A, 16'h1234, 1'b0));
        check("R3 byte flag", word_xfer_o, 1'b0);
        step("R6 first", 1'b0);
        check("R5 incr", bus_addr_o, 24'h5A1235);
        step("R6 second", 1'b0);
        step("R6 final tc", 1'b1);
        check("R5 after final", bus_addr_o, 24'h5A1237);
        step("R7 ignored tc", 1'b0);
        check("R7 ignored addr", bus_addr_o, 24'h5A1237);
    endtask

    task automatic t_byte_wrap;
        do_load(16'hFFFF, 16'd1, 8'h33, 1'b0, 1'b0);
        check("R3 wrap start", bus_addr_o, 24'h33FFFF);
        step("R6 wrap first", 1'b0);
        check("R5 byte 64K wrap", bus_addr_o, 24'h330000);
        step("R6 wrap tc", 1'b1);
    endtask

    task automatic t_word;
        do_load(16'h8001, 16'd0, 8'h4B, 1'b1, 1'b0);
        check("R4 word map", bus_addr_o, 24'h4B0002);
        check("R4 word flag", word_xfer_o, 1'b1);
        step("R6 count zero single", 1'b1);
        do_load(16'h8001, 16'd0, 8'h4A, 1'b1, 1'b0);
        check("R4 page bit0 ignored", bus_addr_o, 24'h4B0002);
        do_load(16'hFFFF, 16'd1, 8'h4A, 1'b1, 1'b0);
        check("R4 word top", bus_addr_o, 24'h4BFFFE);
        step("R6 word first", 1'b0);
        check("R5 word 128K wrap", bus_addr_o, 24'h4A0000);
    endtask

    task automatic t_auto;
        do_load(16'h0100, 16'd1, 8'h10, 1'b0, 1'b1);
        step("R8 first", 1'b0);
        step("R8 tc", 1'b1);
        check("R8 addr reloaded", bus_addr_o, 24'h100100);
        step("R8 keeps running", 1'b0);
        check("R8 next addr", bus_addr_o, 24'h100101);
        step("R8 count reloaded tc", 1'b1);
        autoinit_i = 1'b0;
    endtask

    task automatic t_priority;
        do_load(16'h0500, 16'd0, 8'h01, 1'b0, 1'b0);
        load_i = 1'b1; strobe_i = 1'b1; base_addr_i = 16'h2000; base_cnt_i = 16'd0;
        #1 check("R9 tc blocked by load", tc_o, 1'b0);
        @(negedge clk);
        load_i = 1'b0; strobe_i = 1'b0;
        #1 check("R9 load wins addr", bus_addr_o, 24'h012000);
        step("R9 count intact tc", 1'b1);
    endtask

    task automatic t_full;
        int tc_seen = 0;
        do_load(16'h0000, 16'hFFFF, 8'h02, 1'b1, 1'b0);
        strobe_i = 1'b1;
        for (int i = 0; i < 65535; i++) begin
            #1 if (tc_o) tc_seen++;
            @(negedge clk);
        end
        #1 check("R10 final tc", tc_o, 1'b1);
        @(negedge clk);
        strobe_i = 1'b0;
        #1;
        check("R10 no early tc", tc_seen, 0);
        check("R10 65536 wrap addr", bus_addr_o, 24'h020000);
        step("R7 after full", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_byte();
        t_byte_wrap();
        t_word();
        t_auto();
        t_priority();
        t_full();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule